// File: doc/BRIEF.md
# SD Card 1.8 V Signalling Switch Sequencer

This block is a timed sequencer for the host side of an SD card bus. It moves the bus from 3.3 V to 1.8 V signalling once the card has accepted the voltage-switch command. A one-cycle start pulse launches the sequence.

The sequencer first stops the card clock. It then checks that the card holds all four data lines low. Next it raises the 1.8 V signalling enable and waits 5 ms. After the wait it confirms that the regulator side still reports the enable as set. It then restarts the card clock, waits 1 ms, and expects all four data lines high.

The sequence ends with a one-cycle done pulse, qualified by either an ok flag or a retry flag. Every failure path removes card power, so the surrounding logic can re-run card initialisation at 3.3 V. The data-line levels and the enable read-back pass through two-flop synchronisers before the state machine looks at them. Both wait intervals come from a clock-frequency parameter.

Top module: `sd_vswitch_seq`

## Requirements
- R1: After reset, `card_clk_en_o`=1, `sig18_en_o`=0, `card_pwr_en_o`=1, `busy_o`=0, `done_o`=0, `ok_o`=0, `retry_o`=0.
- R2: A `start_i` high at a clock edge while idle sets `busy_o`=1, `card_clk_en_o`=0 and `card_pwr_en_o`=1 from that edge on, and card power is restored by such a start even after an earlier retry.
- R3: At the next edge the synchronised `dat_i` (bit n is data line n) must equal 4'b0000. Otherwise the sequence ends at that edge with done and retry, so done is seen 2 cycles after the start edge.
- R4: When the low check passes, `sig18_en_o` goes to 1 while the card clock is still off. It is held for exactly LONG_CYC = CLK_HZ/200 cycles (5 ms), and then the synchronised `sig18_rd_i` is sampled. A 0 ends the sequence with retry, 2+LONG_CYC cycles after start.
- R5: When the read-back passes, `card_clk_en_o` returns to 1 with `sig18_en_o` still 1. After exactly SHORT_CYC = CLK_HZ/1000 cycles (1 ms) the synchronised `dat_i` must equal 4'b1111, or the sequence ends with retry.
- R6: On success, `done_o` and `ok_o` are high for one cycle, 2+LONG_CYC+SHORT_CYC cycles after start. `busy_o` drops, and the clock, 1.8 V enable and power outputs all stay 1.
- R7: On any failure, `done_o` and `retry_o` are high for one cycle together, and `card_pwr_en_o`, `sig18_en_o` and `card_clk_en_o` are all 0.
- R8: `start_i` pulses while `busy_o`=1 are ignored and do not change the timing or the outcome of the running sequence.
- R9: `dat_i` and `sig18_rd_i` pass through exactly two register stages before use. A data-line value first applied in the same cycle as the start pulse is not yet seen by the low check, while one applied a cycle earlier is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch pulse, honoured only while idle |
| dat_i | input | 4 | Card data-line levels, bit n = line n |
| sig18_rd_i | input | 1 | Read-back of the 1.8 V signalling enable |
| card_clk_en_o | output | 1 | Card clock enable |
| sig18_en_o | output | 1 | 1.8 V signalling enable |
| card_pwr_en_o | output | 1 | Card power enable |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| ok_o | output | 1 | Switch succeeded, valid with done |
| retry_o | output | 1 | Switch failed, re-initialise at 3.3 V, valid with done |

## Verification
The bench builds the sequencer with CLK_HZ = 20000. This gives a 100-cycle settle window and a 20-cycle clock-on window. With these values every exit point of the sequence (low-check, read-back and high-check failures, and success) can be reached many times in a short run, and each done pulse can be matched to its exact cycle. The short windows also leave room to place a data-line change one cycle either side of the synchroniser boundary, and to fire extra start pulses in the middle of a settle.

// File: rtl/sdvs_pkg.sv
package sdvs_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_LOWCHK = 2'd1,
        PH_SETTLE = 2'd2,
        PH_RESUME = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   clk_en;
        logic   sig18;
        logic   pwr;
        logic   done;
        logic   ok;
        logic   retry;
    } seq_t;
endpackage

// File: rtl/sdvs_sync2.sv
module sdvs_sync2 #(
    parameter int WIDTH = 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic meta_q, sync_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
            end else begin
                meta_q <= d_i[g];
                sync_q <= meta_q;
            end
        end
        assign q_o[g] = sync_q;
    end
endmodule

// File: rtl/sdvs_timer.sv
module sdvs_timer #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    // R4
    count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/sd_vswitch_seq.sv
module sd_vswitch_seq
    import sdvs_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       start_i,
    input  logic [3:0] dat_i,
    input  logic       sig18_rd_i,
    output logic       card_clk_en_o,
    output logic       sig18_en_o,
    output logic       card_pwr_en_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       ok_o,
    output logic       retry_o
);
    localparam int LONG_CYC  = CLK_HZ / 200;
    localparam int SHORT_CYC = CLK_HZ / 1000;
    localparam int TW        = $clog2(LONG_CYC + 1);
    localparam logic [TW-1:0] LONG_M1  = TW'(LONG_CYC - 1);
    localparam logic [TW-1:0] SHORT_M1 = TW'(SHORT_CYC - 1);

    logic [4:0]    sync_in, sync_out;
    logic [3:0]    dat_s;
    logic          rd_s;
    logic          tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;
    seq_t          st_d, st_q;

    assign sync_in = {sig18_rd_i, dat_i};

    sdvs_sync2 #(.WIDTH(5)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (sync_in),
        .q_o    (sync_out)
    );
    assign dat_s = sync_out[3:0];
    assign rd_s  = sync_out[4];

    sdvs_timer #(.W(TW)) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    always_comb begin
        logic fail;
        fail     = 1'b0;
        st_d       = st_q;
        st_d.done  = 1'b0;
        st_d.ok    = 1'b0;
        st_d.retry = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = LONG_M1;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.phase  = PH_LOWCHK;
                    st_d.clk_en = 1'b0;
                    st_d.pwr    = 1'b1;
                end
            end
            PH_LOWCHK: begin
                if (dat_s == 4'b0000) begin
                    st_d.phase = PH_SETTLE;
                    st_d.sig18 = 1'b1;
                    tmr_load   = 1'b1;
                    tmr_val    = LONG_M1;
                end else begin
                    fail = 1'b1;
                end
            end
            PH_SETTLE: begin
                if (tmr_zero) begin
                    if (rd_s) begin
                        st_d.phase  = PH_RESUME;
                        st_d.clk_en = 1'b1;
                        tmr_load    = 1'b1;
                        tmr_val     = SHORT_M1;
                    end else begin
                        fail = 1'b1;
                    end
                end
            end
            PH_RESUME: begin
                if (tmr_zero) begin
                    if (dat_s == 4'b1111) begin
                        st_d.phase = PH_IDLE;
                        st_d.done  = 1'b1;
                        st_d.ok    = 1'b1;
                    end else begin
                        fail = 1'b1;
                    end
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
        if (fail) begin
            st_d.phase  = PH_IDLE;
            st_d.pwr    = 1'b0;
            st_d.sig18  = 1'b0;
            st_d.clk_en = 1'b0;
            st_d.done   = 1'b1;
            st_d.retry  = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{phase: PH_IDLE, clk_en: 1'b1, sig18: 1'b0, pwr: 1'b1,
                      done: 1'b0, ok: 1'b0, retry: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign card_clk_en_o = st_q.clk_en;
    assign sig18_en_o    = st_q.sig18;
    assign card_pwr_en_o = st_q.pwr;
    assign busy_o        = (st_q.phase != PH_IDLE);
    assign done_o        = st_q.done;
    assign ok_o          = st_q.ok;
    assign retry_o       = st_q.retry;

    // R6
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R6
    status_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (ok_o != retry_o));

    // R7
    retry_unpowered_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        retry_o |-> (!card_pwr_en_o && !sig18_en_o && !card_clk_en_o && done_o));

    // R4
    sig18_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sig18_en_o) |-> !card_clk_en_o);

    // R2
    start_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> (!card_clk_en_o && card_pwr_en_o));

    // R5
    resume_sig18_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && $rose(card_clk_en_o)) |-> sig18_en_o);

    // R8
    busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && start_i) |=> (busy_o || done_o));
endmodule

// File: tb/sd_vswitch_seq_tb.sv
module sd_vswitch_seq_tb;
    localparam int CLK_HZ = 20000;
    localparam int L = CLK_HZ / 200;
    localparam int S = CLK_HZ / 1000;

    // stimulus: {dat before switch, dat after clock resumes, read-back kept}
    localparam int NV = 7;
    localparam logic [8:0] VEC [NV] = '{
        {4'h0, 4'hF, 1'b1},
        {4'h5, 4'hF, 1'b1},
        {4'h0, 4'hF, 1'b0},
        {4'h0, 4'hE, 1'b1},
        {4'h8, 4'hF, 1'b1},
        {4'h0, 4'h7, 1'b1},
        {4'h0, 4'hF, 1'b1}
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [3:0] dat = 4'hF;
    logic vkeep = 1'b1;
    logic clk_en, sig18, pwr, busy, done, ok, retry;
    int errors = 0, checks = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sd_vswitch_seq #(.CLK_HZ(CLK_HZ)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dat_i(dat),
        .sig18_rd_i(sig18 & vkeep), .card_clk_en_o(clk_en), .sig18_en_o(sig18),
        .card_pwr_en_o(pwr), .busy_o(busy), .done_o(done), .ok_o(ok), .retry_o(retry)
    );

    task automatic check(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // lead: negedges between applying dlo and the start pulse (0 = same cycle)
    task automatic run(input logic [3:0] dlo, input logic [3:0] dhi, input bit vk,
                       input int lead, input bit extra_start);
        int k, exp_k;
        bit exp_ok;
        @(negedge clk);
        dat = 4'hF; vkeep = vk;
        repeat (3) @(negedge clk);
        if (lead > 0) begin
            dat = dlo;
            repeat (lead) @(negedge clk);
        end else begin
            dat = dlo;
        end
        if (lead == 0)           begin exp_ok = 1'b0; exp_k = 2; end
        else if (dlo != 4'h0)    begin exp_ok = 1'b0; exp_k = 2; end
        else if (!vk)            begin exp_ok = 1'b0; exp_k = 2 + L; end
        else begin exp_ok = (dhi == 4'hF); exp_k = 2 + L + S; end
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 1;
        // R2: gate clock, keep power on, busy
        check(!clk_en && pwr && busy, "R2", {clk_en, pwr, busy}, 3'b011);
        while (!done && k < 1000) begin
            @(negedge clk);
            k++;
            if (clk_en) dat = dhi;
            if (k == 6 && exp_k > 2) begin
                // R4: enable raised with clock still off
                check(sig18 && !clk_en && busy, "R4", {sig18, clk_en, busy}, 3'b101);
            end
            if (extra_start && (k == 10 || k == 11)) start = 1'b1;
            else start = 1'b0;
            if (k == 3 + L && exp_k == 2 + L + S) begin
                // R5: clock back on with enable still set
                check(clk_en && sig18, "R5", {clk_en, sig18}, 2'b11);
            end
        end
        start = 1'b0;
        check(k == exp_k, exp_ok ? "R6" : (exp_k == 2 ? "R3" : (exp_k == 2 + L ? "R4" : "R5")), k, exp_k);
        if (extra_start) check(k == exp_k && ok == exp_ok, "R8", k, exp_k);
        if (lead <= 1 && dlo == 4'h0) check(ok == exp_ok, "R9", ok, exp_ok);
        check(done && ok == exp_ok && retry == !exp_ok, exp_ok ? "R6" : "R7",
              {ok, retry}, {exp_ok, !exp_ok});
        if (exp_ok)
            check(clk_en && sig18 && pwr && !busy, "R6", {clk_en, sig18, pwr, busy}, 4'b1110);
        else
            check(!clk_en && !sig18 && !pwr && !busy, "R7", {clk_en, sig18, pwr, busy}, 4'b0000);
        @(negedge clk);
        // R6 R7: one-cycle done
        check(!done && !ok && !retry, exp_ok ? "R6" : "R7", {done, ok, retry}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(clk_en && !sig18 && pwr && !busy && !done && !ok && !retry, "R1",
              {clk_en, sig18, pwr, busy, done, ok, retry}, 7'b1010000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(clk_en && !sig18 && pwr && !busy && !done, "R1",
              {clk_en, sig18, pwr, busy, done}, 5'b10100);
        for (int i = 0; i < NV; i++) begin
            run(VEC[i][8:5], VEC[i][4:1], VEC[i][0], 3, 1'b0);
        end
        // R8: start pulses during settle are ignored
        run(4'h0, 4'hF, 1'b1, 3, 1'b1);
        // R9: low level applied with the start pulse is not yet seen
        run(4'h0, 4'hF, 1'b1, 0, 1'b0);
        // R9: low level applied one cycle before start is seen
        run(4'h0, 4'hF, 1'b1, 1, 1'b0);
        // R2: power restored by a start after a retry
        run(4'h3, 4'hF, 1'b1, 3, 1'b0);
        run(4'h0, 4'hF, 1'b1, 3, 1'b0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule